// File: doc/BRIEF.md
# Memory Word Buffer with Parity Generation and Checking

This block is the single word register that stands between a word-addressed store and the units that fill it. A data word reaches it from one of three places: the processor, a peripheral controller, or the memory itself on a read. The block captures that word on a load strobe and presents the full stored word, data plus one parity bit, to the memory. Each path handles parity in its own way. A processor word arrives without parity, so the block makes the bit. A peripheral word arrives with its parity bit already attached, so the block checks it. A word read back from memory has its parity checked again.

All parity in the block is odd: a good stored word holds an odd number of ones across its data bits and the parity bit. The parity bit is the top bit of the word, above the data field. A peripheral word that fails its check is never stored. The register keeps its old contents, the memory write enable stays low and a write error pulses for one cycle. A memory word that fails its check is still loaded, because the read has already happened, and a read error pulses for one cycle. All outputs are registered, so every result shows one clock after the load strobe.

Top module: `membuf_par`

## Requirements
- R1: A synchronous active-low reset clears `word_q` to zero and holds `mem_we`, `wr_par_err` and `rd_par_err` low.
- R2: A load with `src` = 2'b00 (processor) stores `{p, cpu_data}` in the next cycle. `p` is the bit that makes the 21-bit word odd. `mem_we` is high in that cycle.
- R3: Whenever `mem_we` is high, `word_q` contains an odd number of ones. Bit 20 of `per_word` and `mem_word` is the parity bit, and bits 19:0 are the data.
- R4: A load with `src` = 2'b01 (peripheral) and odd parity on `per_word` stores `per_word` unchanged and raises `mem_we` for one cycle, with no error.
- R5: A load with `src` = 2'b01 and even parity on `per_word` leaves `word_q` unchanged, keeps `mem_we` low and raises `wr_par_err` for one cycle.
- R6: A load with `src` = 2'b10 (memory) stores `mem_word` unchanged. `mem_we` stays low.
- R7: A memory load whose `mem_word` has even parity still stores the word and raises `rd_par_err` for one cycle. With odd parity, `rd_par_err` stays low.
- R8: With `load` low, or with `src` = 2'b11, `word_q` holds its value and all three strobes stay low.
- R9: At most one of `mem_we`, `wr_par_err`, `rd_par_err` is high in any cycle. Each one is high only in the cycle after the load that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Capture strobe |
| src | input | 2 | Source select: 00 processor, 01 peripheral, 10 memory, 11 unused |
| cpu_data | input | 20 | Processor data, without parity |
| per_word | input | 21 | Peripheral word, with its parity in bit 20 |
| mem_word | input | 21 | Word read from memory, with its parity in bit 20 |
| word_q | output | 21 | Buffered word, with its parity in bit 20 |
| mem_we | output | 1 | One-cycle memory write strobe |
| wr_par_err | output | 1 | One-cycle error flag for a rejected peripheral word |
| rd_par_err | output | 1 | One-cycle error flag for a bad word read from memory |

## Verification
The checker watches every cycle for these properties. Any word offered for writing must have odd parity. The three strobes must never overlap. An idle or unused-source cycle must leave the register and strobes untouched. A rejected peripheral word must leave the register as it was. A bad memory word must still land in the register together with its error pulse. The bench vectors show the exact stored values. These include the generated parity bit for all-zero, all-one and alternating data, and the fact that a processor load ignores any bit above its data field. Only directed scenarios can show the order of events: a strobe falling after one cycle, a rejected write followed by a good one, and a reset in the middle of a load winning over the load.

// File: rtl/membuf_par_pkg.sv
// Package: membuf_par_pkg
// Shared source-select encoding and capture-selection type for the memory
// word buffer. Assumes a two-bit select, with one code left unused.
package membuf_par_pkg;

    typedef enum logic [1:0] {
        SRC_CPU  = 2'b00,
        SRC_PER  = 2'b01,
        SRC_MEM  = 2'b10,
        SRC_NONE = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        CAP_HOLD = 2'b00,
        CAP_CPU  = 2'b01,
        CAP_PER  = 2'b10,
        CAP_MEM  = 2'b11
    } cap_e;

endpackage

// File: rtl/membuf_par_tree.sv
// Module: membuf_par_tree
// XOR reduction over W bits, built as a ripple chain, plus the bit that
// would complete the vector to odd parity.
// Assumes W >= 1. Purely combinational.
module membuf_par_tree #(
    parameter int W = 20
) (
    input  logic [W-1:0] din,
    output logic         xor_all,
    output logic         odd_bit
);
    logic [W-1:0] acc;

    assign acc[0] = din[0];

    // Ripple the running XOR across the vector, one stage per bit.
    generate
        for (genvar i = 1; i < W; i++) begin : g_chain
            assign acc[i] = acc[i-1] ^ din[i];
        end
    endgenerate

    assign xor_all = acc[W-1];
    // An even count of ones needs a one in the parity bit to make it odd.
    assign odd_bit = ~acc[W-1];
endmodule

// File: rtl/membuf_par_chk.sv
// Module: membuf_par_chk
// Odd-parity checker for a full stored word (data plus parity bit).
// Assumes the parity bit is already part of the input vector.
module membuf_par_chk #(
    parameter int WORD_W = 21
) (
    input  logic [WORD_W-1:0] word,
    output logic              ok
);
    logic x;
    logic unused_odd;

    membuf_par_tree #(.W(WORD_W)) u_tree (
        .din     (word),
        .xor_all (x),
        .odd_bit (unused_odd)
    );

    // The word is good when it holds an odd number of ones.
    assign ok = x;
endmodule

// File: rtl/membuf_par_ctl.sv
// Module: membuf_par_ctl
// Decodes the load strobe, the source select and the check results into a
// capture choice and the next values of the three strobes.
// Assumes the check results are valid in the same cycle as load.
module membuf_par_ctl
    import membuf_par_pkg::*;
(
    input  logic load,
    input  src_e src,
    input  logic per_ok,
    input  logic mem_ok,
    output cap_e cap,
    output logic we_d,
    output logic wr_err_d,
    output logic rd_err_d
);
    // Pick the capture source and the strobes for this cycle's request.
    always_comb begin
        cap      = CAP_HOLD;
        we_d     = 1'b0;
        wr_err_d = 1'b0;
        rd_err_d = 1'b0;
        if (load) begin
            unique case (src)
                SRC_CPU: begin
                    cap  = CAP_CPU;
                    we_d = 1'b1;
                end
                SRC_PER: begin
                    if (per_ok) begin
                        cap  = CAP_PER;
                        we_d = 1'b1;
                    end else begin
                        wr_err_d = 1'b1;
                    end
                end
                SRC_MEM: begin
                    cap      = CAP_MEM;
                    rd_err_d = ~mem_ok;
                end
                default: begin
                    cap = CAP_HOLD;
                end
            endcase
        end
    end
endmodule

// File: rtl/membuf_par.sv
// Module: membuf_par (top)
// Word buffer between memory and its writers. It generates odd parity for
// processor data, checks the parity supplied with peripheral words (and
// refuses bad ones), and rechecks words read from memory (it loads them
// anyway and flags them).
// Assumes a synchronous active-low reset and one request per cycle.
module membuf_par
    import membuf_par_pkg::*;
#(
    parameter int DATA_W = 20,
    localparam int WORD_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [1:0]        src,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic [WORD_W-1:0] per_word,
    input  logic [WORD_W-1:0] mem_word,
    output logic [WORD_W-1:0] word_q,
    output logic              mem_we,
    output logic              wr_par_err,
    output logic              rd_par_err
);
    logic              gen_bit;
    logic              gen_x;
    logic              per_ok;
    logic              mem_ok;
    cap_e              cap;
    logic              we_d;
    logic              wr_err_d;
    logic              rd_err_d;
    logic [WORD_W-1:0] word_d;

    membuf_par_tree #(.W(DATA_W)) u_gen (
        .din     (cpu_data),
        .xor_all (gen_x),
        .odd_bit (gen_bit)
    );

    membuf_par_chk #(.WORD_W(WORD_W)) u_chk_per (
        .word (per_word),
        .ok   (per_ok)
    );

    membuf_par_chk #(.WORD_W(WORD_W)) u_chk_mem (
        .word (mem_word),
        .ok   (mem_ok)
    );

    membuf_par_ctl u_ctl (
        .load     (load),
        .src      (src_e'(src)),
        .per_ok   (per_ok),
        .mem_ok   (mem_ok),
        .cap      (cap),
        .we_d     (we_d),
        .wr_err_d (wr_err_d),
        .rd_err_d (rd_err_d)
    );

    // Form the next register value from the chosen capture source.
    always_comb begin
        unique case (cap)
            CAP_CPU: word_d = {gen_bit, cpu_data};
            CAP_PER: word_d = per_word;
            CAP_MEM: word_d = mem_word;
            default: word_d = word_q;
        endcase
    end

    // Register the word and the one-cycle strobes, with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q     <= '0;
            mem_we     <= 1'b0;
            wr_par_err <= 1'b0;
            rd_par_err <= 1'b0;
        end else begin
            word_q     <= word_d;
            mem_we     <= we_d;
            wr_par_err <= wr_err_d;
            rd_par_err <= rd_err_d;
        end
    end

    logic unused_gen_x;
    assign unused_gen_x = gen_x;
endmodule

// File: rtl/membuf_par_sva.sv
// Module: membuf_par_sva
// Checker for membuf_par. It is attached to the top module with bind and
// looks only at the ports. Assumes the source encoding in membuf_par_pkg.
module membuf_par_sva
    import membuf_par_pkg::*;
#(
    parameter int DATA_W = 20,
    localparam int WORD_W = DATA_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic [1:0]        src,
    input logic [DATA_W-1:0] cpu_data,
    input logic [WORD_W-1:0] per_word,
    input logic [WORD_W-1:0] mem_word,
    input logic [WORD_W-1:0] word_q,
    input logic              mem_we,
    input logic              wr_par_err,
    input logic              rd_par_err
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (word_q == '0 && !mem_we && !wr_par_err && !rd_par_err));

    a_r2_cpu_store: assert property (@(posedge clk) disable iff (!rst_n)
        (load && src == SRC_CPU) |=> (mem_we && word_q[DATA_W-1:0] == $past(cpu_data)));

    a_r3_odd_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(word_q) % 2 == 1));

    a_r5_bad_per_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (load && src == SRC_PER && ($countones(per_word) % 2 == 0))
        |=> (wr_par_err && !mem_we && $stable(word_q)));

    a_r7_bad_read_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (load && src == SRC_MEM && ($countones(mem_word) % 2 == 0))
        |=> (rd_par_err && word_q == $past(mem_word)));

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load || src == SRC_NONE)
        |=> ($stable(word_q) && !mem_we && !wr_par_err && !rd_par_err));

    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, wr_par_err, rd_par_err}));
endmodule

bind membuf_par membuf_par_sva #(.DATA_W(DATA_W)) u_sva (.*);

// File: tb/membuf_par_tb.sv
module membuf_par_tb;
    localparam int DATA_W = 20;
    localparam int WORD_W = DATA_W + 1;
    localparam int NVEC   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load = 1'b0;
    logic [1:0]        src = 2'b00;
    logic [DATA_W-1:0] cpu_data = '0;
    logic [WORD_W-1:0] per_word = '0;
    logic [WORD_W-1:0] mem_word = '0;
    logic [WORD_W-1:0] word_q;
    logic              mem_we;
    logic              wr_par_err;
    logic              rd_par_err;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    membuf_par #(.DATA_W(DATA_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .src        (src),
        .cpu_data   (cpu_data),
        .per_word   (per_word),
        .mem_word   (mem_word),
        .word_q     (word_q),
        .mem_we     (mem_we),
        .wr_par_err (wr_par_err),
        .rd_par_err (rd_par_err)
    );

    // Vector: {src[2], load, data[21], exp_word[21], exp_we, exp_wr, exp_rd}
    localparam logic [47:0] VEC [NVEC] = '{
        {2'b00, 1'b1, 21'h000000, 21'h100000, 3'b100}, // R2 zero data
        {2'b00, 1'b1, 21'h000001, 21'h000001, 3'b100}, // R2 one bit
        {2'b00, 1'b1, 21'h0FFFFF, 21'h1FFFFF, 3'b100}, // R2 all ones
        {2'b00, 1'b1, 21'h100007, 21'h000007, 3'b100}, // R2 top bit ignored
        {2'b01, 1'b1, 21'h000001, 21'h000001, 3'b100}, // R4 good
        {2'b01, 1'b1, 21'h000003, 21'h000001, 3'b010}, // R5 bad, hold
        {2'b01, 1'b1, 21'h0ABCDE, 21'h0ABCDE, 3'b100}, // R4 good after bad
        {2'b00, 1'b0, 21'h012345, 21'h0ABCDE, 3'b000}, // R8 no load
        {2'b11, 1'b1, 21'h000001, 21'h0ABCDE, 3'b000}, // R8 unused source
        {2'b10, 1'b1, 21'h100000, 21'h100000, 3'b000}, // R6 good read
        {2'b10, 1'b1, 21'h000000, 21'h000000, 3'b001}, // R7 bad read loaded
        {2'b10, 1'b1, 21'h1FFFFF, 21'h1FFFFF, 3'b000}, // R6 all ones
        {2'b01, 1'b1, 21'h1FFFFE, 21'h1FFFFF, 3'b010}, // R5 bad, hold
        {2'b10, 1'b1, 21'h055555, 21'h055555, 3'b001}, // R7 alternating
        {2'b00, 1'b1, 21'h055555, 21'h155555, 3'b100}, // R2 alternating
        {2'b00, 1'b0, 21'h000000, 21'h155555, 3'b000}  // R9 strobe drops
    };

    task automatic check(input string req, input logic [WORD_W-1:0] w,
                         input logic [2:0] fl);
        checks++;
        if (word_q !== w || {mem_we, wr_par_err, rd_par_err} !== fl) begin
            errors++;
            $display("FAIL %s: word=%h flags=%b expected word=%h flags=%b",
                     req, word_q, {mem_we, wr_par_err, rd_par_err}, w, fl);
        end
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        check("R1 reset", '0, 3'b000);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            src      = VEC[i][47:46];
            load     = VEC[i][45];
            cpu_data = VEC[i][44:24+DATA_W-20];
            per_word = VEC[i][44:24];
            mem_word = VEC[i][44:24];
            @(negedge clk);
            check($sformatf("R2-R9 vector %0d", i), VEC[i][23:3], VEC[i][2:0]);
            if (mem_we) begin
                checks++;
                if ($countones(word_q) % 2 != 1) begin
                    errors++;
                    $display("FAIL R3: word=%h has even ones, expected odd", word_q);
                end
            end
        end

        // R9: back-to-back loads, each strobe lasts one cycle
        src = 2'b01; load = 1'b1; per_word = 21'h000003;
        @(negedge clk);
        check("R9 wr err first", 21'h155555, 3'b010);
        src = 2'b10; mem_word = 21'h000006;
        @(negedge clk);
        check("R9 rd err next", 21'h000006, 3'b001);
        load = 1'b0;
        @(negedge clk);
        check("R9 quiet", 21'h000006, 3'b000);

        // R1: reset wins over a concurrent processor load
        rst_n = 1'b0; load = 1'b1; src = 2'b00; cpu_data = 20'h00001;
        @(negedge clk);
        check("R1 reset over load", '0, 3'b000);
        rst_n = 1'b1; load = 1'b0;
        @(negedge clk);
        check("R1 after reset idle", '0, 3'b000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule